// File: doc/BRIEF.md
# Nonvolatile Store and Recall Arbiter

This block decides when a battery-backed static memory copies its contents into nonvolatile cells (a store) or reloads them from those cells (a recall). Store requests come from three places: a shared open-drain store line that other chips or a button can pull low, a power-loss detector, and a software command decoder. Recall requests come from the software command decoder. The block tracks whether the array has been written since the last nonvolatile operation. It skips store requests from the line or from power loss when nothing has changed. It gives a memory access already in flight time to finish, and then times the operation. The nonvolatile cells are modelled only as timers.

During a store the block pulls the shared line low, so that it also serves as a busy flag. While a store or recall runs, the SRAM is disabled. After a store the SRAM stays disabled until the line reads high again. Before the store, a grace phase lets reads proceed, but new writes are refused. The start pulses tell the cell model when to begin a store or a recall.

Top module: `nvs_store_arbiter`

## Requirements
- R1: While reset is held, and in the cycle after it, every output is low.
- R2: When the array has been written and the store line is low while the block is idle, the block drives `busy_pull_o` from the next cycle on. For the first GRACE_CYCLES cycles it also raises `wr_block_o` and keeps `sram_block_o` low. In the cycle after that phase, `store_start_o` pulses for one cycle.
- R3: A store keeps `busy_pull_o` and `sram_block_o` high for exactly STORE_CYCLES cycles, counted from the `store_start_o` cycle. After that, `busy_pull_o` drops.
- R4: When a store ends, `sram_block_o` stays high for as long as the store line reads low. It falls one cycle after the line is sampled high.
- R5: When the store line goes low while the array is clean, no store takes place: `busy_pull_o` and `store_start_o` stay low. `sram_block_o` is high from the next cycle until one cycle after the line is sampled high.
- R6: A power-loss pulse while the array is clean has no effect: all outputs stay low. While the array is dirty, the pulse starts the same grace and store sequence as R2.
- R7: A software store pulse starts the R2 grace and store sequence, whether or not the array is dirty.
- R8: A software recall pulse blocks the SRAM for RECALL_CYCLES cycles, starting with a one-cycle `recall_start_o`. It never drives `busy_pull_o`, and it leaves the array clean.
- R9: A completed store leaves the array clean, so a later low on the store line gives the R5 outcome.
- R10: A write strobe in the same cycle as a request counts as a write, and makes the array dirty for that request. A write strobe while `wr_block_o` or `sram_block_o` is high does not make the array dirty.
- R11: When several requests arrive in the same idle cycle, the order of precedence is: a power-loss pulse that is eligible (dirty array), then the store line, then the software store, then the software recall. Requests that arrive while the block is busy are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| store_line_i | input | 1 | Sampled level of the shared open-drain store line (0 = pulled low) |
| pwr_loss_req_i | input | 1 | One-cycle pulse: the supply dropped below its trigger level |
| sw_store_req_i | input | 1 | One-cycle pulse: the software command decoder asks for a store |
| sw_recall_req_i | input | 1 | One-cycle pulse: the software command decoder asks for a recall |
| sram_wr_strobe_i | input | 1 | A write to the SRAM array is requested this cycle |
| busy_pull_o | output | 1 | Enable for the open-drain pull-down on the store line |
| sram_block_o | output | 1 | Disables all SRAM reads and writes |
| wr_block_o | output | 1 | Refuses new SRAM writes during the grace phase |
| store_start_o | output | 1 | One-cycle pulse that starts the store timer of the cell model |
| recall_start_o | output | 1 | One-cycle pulse that starts the recall of the cell model |

## Verification
Two events can fall in the same cycle: a write strobe and the request it would race against. The block also has to choose among several requests that arrive together. The bench sweeps every combination of the four request inputs, crossed with the prior array state (clean or dirty) and with a write strobe in the same cycle or not. For each combination it computes which operation should win from the precedence order and the effective dirty state. It then compares every output, cycle by cycle, against the phase lengths. Separate runs place write strobes inside a hold phase, and issue a line request after a completed store. The outcome (store or no store) shows whether the array was seen as dirty.

// File: rtl/nvs_pkg.sv
// Package: shared types for the store/recall arbiter.
// Assumes: one clock domain, request inputs already synchronised.
package nvs_pkg;

    // Phases of the operation sequencer.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GRACE  = 3'd1,
        ST_STORE  = 3'd2,
        ST_RECALL = 3'd3,
        ST_HOLD   = 3'd4
    } nvs_state_e;

    // Outcome of request selection in an idle cycle.
    typedef enum logic [1:0] {
        GR_NONE   = 2'd0,
        GR_STORE  = 2'd1,
        GR_HOLD   = 2'd2,
        GR_RECALL = 2'd3
    } nvs_grant_e;

endpackage

// File: rtl/nvs_dirty_track.sv
// Module: nvs_dirty_track
// Records whether the SRAM array was written since the last completed
// store or recall. A write strobe counts only when the SRAM is neither
// blocked nor in the write-refusing grace phase.
// dirty_now_o also covers a write accepted in the current cycle.
// Assumes: clear_i and an accepted write never coincide, because clear_i
// is raised only while the SRAM is blocked.
module nvs_dirty_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_strobe_i,
    input  logic wr_block_i,
    input  logic sram_block_i,
    input  logic clear_i,
    output logic dirty_now_o
);

    logic dirty_q;
    logic wr_ok;

    // A write takes effect only while the array is fully open.
    assign wr_ok = wr_strobe_i && !wr_block_i && !sram_block_i;

    // Sticky dirty flag, cleared by a finished nonvolatile operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dirty_q <= 1'b0;
        end else if (clear_i) begin
            dirty_q <= 1'b0;
        end else if (wr_ok) begin
            dirty_q <= 1'b1;
        end
    end

    // A write racing a request in the same cycle already counts.
    assign dirty_now_o = dirty_q || wr_ok;

endmodule

// File: rtl/nvs_req_select.sv
// Module: nvs_req_select
// Selects the single operation to begin in an idle cycle.
// Eligibility first: a power-loss request needs a dirty array.
// Precedence among the eligible requests: power loss, store line,
// software store, software recall.
// A store-line request on a clean array becomes a hold: no store runs,
// but the SRAM stays off until the line is released.
// Assumes: the caller ignores the grant outside the idle phase.
module nvs_req_select
    import nvs_pkg::*;
(
    input  logic       idle_i,
    input  logic       dirty_i,
    input  logic       pwr_loss_i,
    input  logic       line_low_i,
    input  logic       sw_store_i,
    input  logic       sw_recall_i,
    output nvs_grant_e grant_o
);

    // Fixed-precedence choice with source-dependent eligibility.
    always_comb begin
        grant_o = GR_NONE;
        if (idle_i) begin
            if (pwr_loss_i && dirty_i) begin
                grant_o = GR_STORE;
            end else if (line_low_i) begin
                grant_o = dirty_i ? GR_STORE : GR_HOLD;
            end else if (sw_store_i) begin
                grant_o = GR_STORE;
            end else if (sw_recall_i) begin
                grant_o = GR_RECALL;
            end
        end
    end

endmodule

// File: rtl/nvs_op_sequencer.sv
// Module: nvs_op_sequencer
// Runs the phases grace -> store -> hold, or recall alone, with one shared
// phase counter. All outputs decode the state register, so none depends
// combinationally on an input.
// Assumes: each phase length parameter is at least 1.
module nvs_op_sequencer
    import nvs_pkg::*;
#(
    parameter int GRACE_CYCLES  = 125,
    parameter int STORE_CYCLES  = 1250000,
    parameter int RECALL_CYCLES = 2500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  nvs_grant_e grant_i,
    input  logic       line_high_i,
    output logic       idle_o,
    output logic       busy_pull_o,
    output logic       wr_block_o,
    output logic       sram_block_o,
    output logic       store_start_o,
    output logic       recall_start_o,
    output logic       dirty_clear_o
);

    localparam int MAX_A  = (GRACE_CYCLES > STORE_CYCLES) ? GRACE_CYCLES : STORE_CYCLES;
    localparam int MAX_C  = (MAX_A > RECALL_CYCLES) ? MAX_A : RECALL_CYCLES;
    localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;
    localparam logic [CW-1:0] G_LAST = CW'(GRACE_CYCLES - 1);
    localparam logic [CW-1:0] S_LAST = CW'(STORE_CYCLES - 1);
    localparam logic [CW-1:0] R_LAST = CW'(RECALL_CYCLES - 1);

    nvs_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next phase and counter value.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                unique case (grant_i)
                    GR_STORE:  state_d = ST_GRACE;
                    GR_HOLD:   state_d = ST_HOLD;
                    GR_RECALL: state_d = ST_RECALL;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_GRACE: begin
                if (cnt_q == G_LAST) begin
                    state_d = ST_STORE;
                    cnt_d   = '0;
                end
            end
            ST_STORE: begin
                if (cnt_q == S_LAST) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end
            end
            ST_RECALL: begin
                if (cnt_q == R_LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            end
            ST_HOLD: begin
                cnt_d = '0;
                if (line_high_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output decode from the registered phase.
    always_comb begin
        idle_o         = (state_q == ST_IDLE);
        busy_pull_o    = (state_q == ST_GRACE) || (state_q == ST_STORE);
        wr_block_o     = (state_q == ST_GRACE);
        sram_block_o   = (state_q == ST_STORE) || (state_q == ST_RECALL) ||
                         (state_q == ST_HOLD);
        store_start_o  = (state_q == ST_STORE)  && (cnt_q == '0);
        recall_start_o = (state_q == ST_RECALL) && (cnt_q == '0);
        dirty_clear_o  = ((state_q == ST_STORE)  && (cnt_q == S_LAST)) ||
                         ((state_q == ST_RECALL) && (cnt_q == R_LAST));
    end

endmodule

// File: rtl/nvs_store_arbiter.sv
// Module: nvs_store_arbiter (top)
// Arbitrates stores from the store line, power loss and software, and
// recalls from software. It tracks writes to skip needless stores,
// allows a grace phase before each store, drives the store line low as a
// busy flag, and gates the SRAM.
// Assumes: store_line_i reflects this block's own pull-down as well as
// external drivers; request pulses are one cycle wide.
module nvs_store_arbiter
    import nvs_pkg::*;
#(
    parameter int GRACE_CYCLES  = 125,
    parameter int STORE_CYCLES  = 1250000,
    parameter int RECALL_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic store_line_i,
    input  logic pwr_loss_req_i,
    input  logic sw_store_req_i,
    input  logic sw_recall_req_i,
    input  logic sram_wr_strobe_i,
    output logic busy_pull_o,
    output logic sram_block_o,
    output logic wr_block_o,
    output logic store_start_o,
    output logic recall_start_o
);

    logic       idle;
    logic       dirty_now;
    logic       dirty_clear;
    nvs_grant_e grant;

    nvs_dirty_track u_dirty (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_strobe_i  (sram_wr_strobe_i),
        .wr_block_i   (wr_block_o),
        .sram_block_i (sram_block_o),
        .clear_i      (dirty_clear),
        .dirty_now_o  (dirty_now)
    );

    nvs_req_select u_select (
        .idle_i      (idle),
        .dirty_i     (dirty_now),
        .pwr_loss_i  (pwr_loss_req_i),
        .line_low_i  (!store_line_i),
        .sw_store_i  (sw_store_req_i),
        .sw_recall_i (sw_recall_req_i),
        .grant_o     (grant)
    );

    nvs_op_sequencer #(
        .GRACE_CYCLES  (GRACE_CYCLES),
        .STORE_CYCLES  (STORE_CYCLES),
        .RECALL_CYCLES (RECALL_CYCLES)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .grant_i        (grant),
        .line_high_i    (store_line_i),
        .idle_o         (idle),
        .busy_pull_o    (busy_pull_o),
        .wr_block_o     (wr_block_o),
        .sram_block_o   (sram_block_o),
        .store_start_o  (store_start_o),
        .recall_start_o (recall_start_o),
        .dirty_clear_o  (dirty_clear)
    );

endmodule

// File: rtl/nvs_store_arbiter_chk.sv
// Module: nvs_store_arbiter_chk
// Port-level temporal checks for nvs_store_arbiter, attached with bind.
// Assumes: the same parameter values as the bound instance.
module nvs_store_arbiter_chk #(
    parameter int STORE_CYCLES = 1250000
) (
    input logic clk,
    input logic rst_n,
    input logic store_line_i,
    input logic busy_pull_o,
    input logic sram_block_o,
    input logic wr_block_o,
    input logic store_start_o,
    input logic recall_start_o
);

    localparam int LW = $clog2(STORE_CYCLES + 1) + 1;

    logic [LW-1:0] st_len;
    logic          quiet;

    assign quiet = !busy_pull_o && !sram_block_o && !wr_block_o;

    // Length of the current run with both the pull and the block active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_len <= '0;
        end else if (busy_pull_o && sram_block_o) begin
            st_len <= st_len + 1'b1;
        end else begin
            st_len <= '0;
        end
    end

    // R2: a low line seen while idle is answered in the next cycle.
    p_line_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !store_line_i) |=> (busy_pull_o || sram_block_o));

    // R2: a store starts only straight after a grace cycle.
    p_grace_before_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        store_start_o |-> ($past(wr_block_o) && busy_pull_o && sram_block_o));

    // R2: during grace the pull is on and reads remain open.
    p_grace_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block_o |-> (busy_pull_o && !sram_block_o));

    // R3 and R4: the pull ends after exactly the store length; the SRAM stays off.
    p_store_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_pull_o) |-> ((st_len == LW'(STORE_CYCLES)) && sram_block_o));

    // R8: a recall blocks the SRAM without using the store line.
    p_recall_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recall_start_o |-> (sram_block_o && !busy_pull_o && !wr_block_o));

endmodule

bind nvs_store_arbiter nvs_store_arbiter_chk #(
    .STORE_CYCLES (STORE_CYCLES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .store_line_i   (store_line_i),
    .busy_pull_o    (busy_pull_o),
    .sram_block_o   (sram_block_o),
    .wr_block_o     (wr_block_o),
    .store_start_o  (store_start_o),
    .recall_start_o (recall_start_o)
);

// File: tb/tb_nvs_store_arbiter.sv
// Bench: sweeps every request combination against the array state and a
// same-cycle write, with the expected waveform computed from phase lengths.
module tb_nvs_store_arbiter;

    localparam int G = 3;
    localparam int S = 5;
    localparam int R = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic pwr = 1'b0, sws = 1'b0, swr = 1'b0, wr = 1'b0;
    logic store_line;
    logic busy_pull, sram_block, wr_block, store_start, recall_start;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    // Open-drain line: low if any driver pulls.
    assign store_line = ~(ext_low | busy_pull);

    nvs_store_arbiter #(
        .GRACE_CYCLES  (G),
        .STORE_CYCLES  (S),
        .RECALL_CYCLES (R)
    ) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .store_line_i     (store_line),
        .pwr_loss_req_i   (pwr),
        .sw_store_req_i   (sws),
        .sw_recall_req_i  (swr),
        .sram_wr_strobe_i (wr),
        .busy_pull_o      (busy_pull),
        .sram_block_o     (sram_block),
        .wr_block_o       (wr_block),
        .store_start_o    (store_start),
        .recall_start_o   (recall_start)
    );

    task automatic step();
        @(negedge clk);
    endtask

    // Compare {busy, wr_block, sram_block, store_start, recall_start}.
    task automatic chk(input logic [4:0] exp, input string req);
        logic [4:0] act;
        act = {busy_pull, wr_block, sram_block, store_start, recall_start};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Hold phase: line kept low for nh cycles, then released.
    task automatic hold_tail(input int nh, input string req);
        for (int j = 0; j < nh; j++) begin
            chk(5'b00100, req);
            step();
        end
        ext_low = 1'b0;
        chk(5'b00100, req);
        step();
        chk(5'b00000, req);
    endtask

    task automatic run_case(input bit p, input bit h, input bit s, input bit r,
                            input bit d, input bit w);
        bit    ed;
        int    kind;
        string tag;
        // Leave the array clean with a recall, then optionally dirty it.
        swr = 1'b1; step(); swr = 1'b0;
        repeat (R) step();
        if (d) begin
            wr = 1'b1; step(); wr = 1'b0;
        end
        // Apply the requests together.
        pwr = p; ext_low = h; sws = s; swr = r; wr = w;
        step();
        pwr = 1'b0; sws = 1'b0; swr = 1'b0; wr = 1'b0;
        ed = d | w;
        // kind: 0 none, 1 store, 2 hold, 3 recall
        if (p && ed)      kind = 1;
        else if (h)       kind = ed ? 1 : 2;
        else if (s)       kind = 1;
        else if (r)       kind = 3;
        else              kind = 0;
        if ((int'(p) + int'(h) + int'(s) + int'(r)) > 1) tag = "R11";
        else if (w && !d && kind == 1 && !s) tag = "R10";
        else if (p)       tag = "R6";
        else if (h)       tag = ed ? "R2" : "R5";
        else if (s)       tag = "R7";
        else if (r)       tag = "R8";
        else              tag = "R6";
        case (kind)
            1: begin
                for (int k = 1; k <= G + S; k++) begin
                    chk({1'b1, k <= G, k > G, k == G + 1, 1'b0}, (k > G) ? "R3" : tag);
                    step();
                end
                hold_tail(h ? 3 : 0, "R4");
            end
            2: hold_tail(3, tag);
            3: begin
                for (int k = 1; k <= R; k++) begin
                    chk({4'b0010, k == 1}, tag);
                    step();
                end
                chk(5'b00000, tag);
            end
            default: chk(5'b00000, tag);
        endcase
        ext_low = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        chk(5'b00000, "R1");
        rst_n = 1'b1;
        step();
        chk(5'b00000, "R1");

        // Full sweep: requests x prior array state x same-cycle write.
        for (int d = 0; d < 2; d++) begin
            for (int w = 0; w < 2; w++) begin
                for (int q = 0; q < 16; q++) begin
                    run_case(q[3], q[2], q[1], q[0], d[0], w[0]);
                end
            end
        end

        // R9: a completed store cleans the array.
        wr = 1'b1; step(); wr = 1'b0;
        sws = 1'b1; step(); sws = 1'b0;
        repeat (G + S + 1) step();
        chk(5'b00000, "R9");
        ext_low = 1'b1; step();
        chk(5'b00100, "R9");
        ext_low = 1'b0; step();
        chk(5'b00000, "R9");

        // R10: a write during a hold is not counted.
        swr = 1'b1; step(); swr = 1'b0;
        repeat (R) step();
        ext_low = 1'b1; step();
        wr = 1'b1; step(); wr = 1'b0;
        ext_low = 1'b0; step();
        chk(5'b00000, "R10");
        ext_low = 1'b1; step();
        chk(5'b00100, "R10");
        ext_low = 1'b0; step();
        chk(5'b00000, "R10");

        // R11: a request that arrives mid-operation is dropped.
        sws = 1'b1; step(); sws = 1'b0;
        swr = 1'b1; step(); swr = 1'b0;
        repeat (G + S) step();
        chk(5'b00000, "R11");
        step();
        chk(5'b00000, "R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule